// File: doc/BRIEF.md
# Folded Single-Port SRAM with Column Multiplexing

This block is a synchronous single-port memory of 2048 sixteen-bit words. It does not keep a flat word array. The words sit in a folded physical array of 256 rows by 128 columns, which puts eight words on every row.

The upper address bits choose a row through a predecoded row decoder, which drives a one-hot wordline. The low address bits choose one of eight column groups. Sixteen 8:1 column multiplexers, one per data bit, take the addressed word out of the selected row. A write touches only the sixteen physical columns of the addressed group. The other 112 bits of the row keep their values.

Reads are registered. The wordline vector is brought out as a port, so that decode behaviour can be seen from outside the block.

Top module: `sram_fold`

## Requirements
- R1: The address is split with bits [10:3] selecting the row and bits [2:0] selecting the column group. An enabled read of any of the 2048 addresses returns the word last written there.
- R2: A read cycle is a rising edge with `ce`=1 and `we`=0. The word read appears on `rdata` right after that edge and is not visible earlier.
- R3: `rdata` holds its value across every edge that is not a read cycle, including write cycles and cycles with `ce`=0.
- R4: A write cycle is a rising edge with `ce`=1 and `we`=1. It updates only the addressed word, and the other seven words sharing its row are unchanged.
- R5: While `ce`=1, exactly one bit of `wordline` is high. While `ce`=0, no bit of `wordline` is high.
- R6: With `ce`=1, the asserted wordline bit has index equal to address bits [10:3], that is `wordline` == 1 << addr[10:3].
- R7: An edge with `ce`=0 and `we`=1 changes no stored word.
- R8: While `rst_n` is low, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Chip enable |
| we | input | 1 | Write enable, 1 = write, 0 = read |
| addr | input | 11 | Word address: [10:3] row, [2:0] column group |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| wordline | output | 256 | One-hot row select from the row decoder |

## Verification
First, every address is written once with a value that depends on its address, then read back. This pass catches any fold or interleave error that would alias two addresses onto the same physical bits.

Directed sequences then cover three cases:
- writing one word and reading its seven row neighbours, which tells a masked column write apart from a whole-row write;
- writes issued with chip enable low;
- idle and write cycles between reads, which show whether the read register holds.

Seeded random traffic mixes reads, writes and idle cycles across the whole address space, compared against a flat reference array. The wordline is compared against the expected one-hot row code on every cycle.

// File: rtl/sram_fold_pkg.sv
package sram_fold_pkg;
  // Geometry shared by all parts of the folded array
  localparam int ROW_BITS_DEF = 8;
  localparam int COL_BITS_DEF = 3;
  localparam int DATA_W_DEF   = 16;
  localparam int PRE_W_DEF    = 2;   // address bits per predecode group
endpackage

// File: rtl/sram_fold_rowdec.sv
module sram_fold_rowdec #(
  parameter int ROW_BITS = 8,
  parameter int PRE_W    = 2,
  localparam int ROWS    = 1 << ROW_BITS,
  localparam int NGRP    = ROW_BITS / PRE_W,
  localparam int GSIZE   = 1 << PRE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [ROW_BITS-1:0] row_addr,
  output logic [ROWS-1:0]     wl
);
  logic [NGRP-1:0][GSIZE-1:0] pre;

  // Predecode: each group of address bits becomes a small one-hot code
  for (genvar g = 0; g < NGRP; g++) begin : gen_pre
    always_comb begin
      pre[g] = '0;
      if (en) pre[g][row_addr[g*PRE_W +: PRE_W]] = 1'b1;
    end
  end

  // Final stage: each wordline is the AND of one line per group
  for (genvar r = 0; r < ROWS; r++) begin : gen_wl
    localparam logic [ROW_BITS-1:0] RV = ROW_BITS'(r);
    always_comb begin
      wl[r] = 1'b1;
      for (int g = 0; g < NGRP; g++) wl[r] = wl[r] & pre[g][RV[g*PRE_W +: PRE_W]];
    end
  end

  AST_WL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> $countones(wl) == 1);  // R5
  AST_WL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> wl == '0);  // R5
endmodule

// File: rtl/sram_fold_colmux.sv
module sram_fold_colmux #(
  parameter int COL_BITS = 3,
  parameter int DATA_W   = 16,
  localparam int MUX     = 1 << COL_BITS,
  localparam int COLS    = MUX * DATA_W
) (
  input  logic [COLS-1:0]     row_bits,
  input  logic [COL_BITS-1:0] sel,
  output logic [DATA_W-1:0]   word
);
  // One 8:1 mux per data bit; bit b of group c lives at column MUX*b + c
  for (genvar b = 0; b < DATA_W; b++) begin : gen_mux
    logic [MUX-1:0] slice;
    assign slice   = row_bits[b*MUX +: MUX];
    assign word[b] = slice[sel];
  end
endmodule

// File: rtl/sram_fold_array.sv
module sram_fold_array #(
  parameter int ROW_BITS = 8,
  parameter int COLS     = 128,
  localparam int ROWS    = 1 << ROW_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ROWS-1:0]     wl,
  input  logic                wr_en,
  input  logic [COLS-1:0]     col_mask,
  input  logic [COLS-1:0]     col_data,
  input  logic [ROW_BITS-1:0] rd_row,
  output logic [COLS-1:0]     rd_bits
);
  logic [COLS-1:0] row_bus [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : gen_row
    logic [COLS-1:0] cells_q;
    logic [COLS-1:0] cells_d;
    logic            row_we;
    assign row_we  = wl[r] & wr_en;
    assign cells_d = (cells_q & ~col_mask) | (col_data & col_mask);
    always_ff @(posedge clk) begin
      if (row_we) cells_q <= cells_d;
    end
    assign row_bus[r] = cells_q;
  end

  assign rd_bits = row_bus[rd_row];

  AST_WL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|wl) |-> wl[rd_row]);  // R6
  AST_MASK_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $countones(col_mask) == COLS / 8);  // R4
endmodule

// File: rtl/sram_fold.sv
module sram_fold
  import sram_fold_pkg::*;
#(
  parameter int ROW_BITS = ROW_BITS_DEF,
  parameter int COL_BITS = COL_BITS_DEF,
  parameter int DATA_W   = DATA_W_DEF,
  parameter int PRE_W    = PRE_W_DEF,
  localparam int ADDR_W  = ROW_BITS + COL_BITS,
  localparam int ROWS    = 1 << ROW_BITS,
  localparam int MUX     = 1 << COL_BITS,
  localparam int COLS    = MUX * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [ROWS-1:0]   wordline
);
  logic [ROW_BITS-1:0] row_a;
  logic [COL_BITS-1:0] col_a;
  logic [COLS-1:0]     col_mask;
  logic [COLS-1:0]     col_data;
  logic [COLS-1:0]     row_bits;
  logic [DATA_W-1:0]   mux_word;
  logic [DATA_W-1:0]   rdata_d;
  logic                rd_cyc;

  assign row_a  = addr[ADDR_W-1:COL_BITS];
  assign col_a  = addr[COL_BITS-1:0];
  assign rd_cyc = ce & ~we;

  // Spread the write word onto the interleaved columns of one group
  for (genvar b = 0; b < DATA_W; b++) begin : gen_wr
    for (genvar c = 0; c < MUX; c++) begin : gen_grp
      assign col_mask[b*MUX + c] = (col_a == COL_BITS'(c));
      assign col_data[b*MUX + c] = wdata[b];
    end
  end

  sram_fold_rowdec #(.ROW_BITS(ROW_BITS), .PRE_W(PRE_W)) u_rowdec (
    .clk(clk), .rst_n(rst_n), .en(ce), .row_addr(row_a), .wl(wordline)
  );

  sram_fold_array #(.ROW_BITS(ROW_BITS), .COLS(COLS)) u_array (
    .clk(clk), .rst_n(rst_n), .wl(wordline), .wr_en(we),
    .col_mask(col_mask), .col_data(col_data), .rd_row(row_a), .rd_bits(row_bits)
  );

  sram_fold_colmux #(.COL_BITS(COL_BITS), .DATA_W(DATA_W)) u_colmux (
    .row_bits(row_bits), .sel(col_a), .word(mux_word)
  );

  // Output register: next-state and storage written separately
  always_comb begin
    rdata_d = rdata;
    if (rd_cyc) rdata_d = mux_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_d;
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ce && !we) |=> $stable(rdata));  // R3
  AST_WR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |-> wordline == '0);  // R7
endmodule

// File: tb/sram_fold_bench.sv
`timescale 1ns/1ps
module sram_fold_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         ce, we;
  logic [10:0]  addr;
  logic [15:0]  wdata;
  logic [15:0]  rdata;
  logic [255:0] wordline;

  int checks = 0;
  int errors = 0;
  logic [15:0] ref_mem [2048];
  logic [15:0] last_rd;

  always #10 clk = ~clk;  // 50 MHz

  sram_fold u_sram_fold (
    .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .wordline(wordline)
  );

  function automatic logic [255:0] exp_wl(input logic en, input logic [10:0] a);
    if (!en) return '0;
    return 256'b1 << a[10:3];
  endfunction

  function automatic logic [15:0] seed_word(input logic [10:0] a);
    return {a[2:0], ~a[7:0], a[10:6]} ^ 16'h5A3C;
  endfunction

  task automatic chk16(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_wl(input string req);
    logic [255:0] e;
    e = exp_wl(ce, addr);
    checks++;
    if (wordline !== e) begin
      errors++;
      $display("FAIL %s wordline act=%h exp=%h", req, wordline, e);
    end
  endtask

  // Each task starts and ends just after a falling edge
  task automatic do_write(input logic [10:0] a, input logic [15:0] d);
    ce = 1; we = 1; addr = a; wdata = d;
    #1 chk_wl("R5/R6 write");
    @(negedge clk);
    ref_mem[a] = d;
    chk16("R3 write keeps rdata", rdata, last_rd);
  endtask

  task automatic do_read(input logic [10:0] a, input string req);
    ce = 1; we = 0; addr = a; wdata = $urandom;
    #1 chk_wl("R5/R6 read");
    chk16("R2 not early", rdata, last_rd);
    @(negedge clk);
    chk16(req, rdata, ref_mem[a]);
    last_rd = ref_mem[a];
  endtask

  task automatic do_idle(input logic wr_flag, input logic [10:0] a);
    ce = 0; we = wr_flag; addr = a; wdata = $urandom;
    #1 chk_wl("R5 idle");
    @(negedge clk);
    chk16("R3 idle keeps rdata", rdata, last_rd);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    rst_n = 0; ce = 0; we = 0; addr = '0; wdata = '0;
    last_rd = '0;
    repeat (3) @(negedge clk);
    chk16("R8 reset", rdata, 16'h0000);
    rst_n = 1;
    @(negedge clk);

    // R1: fill every word, then read every word back
    for (int i = 0; i < 2048; i++) do_write(11'(i), seed_word(11'(i)));
    for (int i = 0; i < 2048; i++) do_read(11'(i), "R1 full sweep");

    // R4: one write, seven row neighbours untouched
    do_write(11'h2A5, 16'hBEEF);
    for (int c = 0; c < 8; c++) do_read({8'h54, 3'(c)}, "R4 row neighbours");
    do_write(11'h7FF, 16'hFFFF);
    do_write(11'h000, 16'h0000);
    do_read(11'h7FF, "R1 top address");
    do_read(11'h7F8, "R4 top row neighbour");
    do_read(11'h000, "R1 bottom address");
    do_read(11'h001, "R4 bottom row neighbour");

    // R7: writes with ce low are dropped
    wdata = 16'h1234;
    do_idle(1'b1, 11'h2A5);
    do_idle(1'b1, 11'h123);
    do_read(11'h2A5, "R7 ce low write ignored");
    do_read(11'h123, "R7 ce low write ignored");

    // Random mix against the flat reference
    for (int n = 0; n < 4000; n++) begin
      int unsigned op;
      logic [10:0] a;
      op = $urandom_range(0, 9);
      a  = 11'($urandom);
      if (op < 4)      do_write(a, 16'($urandom));
      else if (op < 8) do_read(a, "R1 random read");
      else             do_idle(op[0], a);
    end

    // R8: reset clears the output register
    rst_n = 0;
    #1 chk16("R8 reset again", rdata, 16'h0000);
    @(negedge clk);
    rst_n = 1;
    last_rd = '0;
    @(negedge clk);
    do_read(11'h2A5, "R1 after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule